// File: doc/BRIEF.md
# Memory Controller Status Register Block

This block is the software-visible control and status register file that sits beside an on-chip memory controller. It is reached over a 32-bit APB-style bus with word-only accesses and drives one level-sensitive interrupt line. Eleven hardware event inputs each set a bit of an interrupt status group. Software clears those bits by writing ones, and it controls which bits reach the interrupt line through separate set-enable and set-disable registers that act on a read-only mask.

Alongside the interrupt group, the block keeps first-failure capture registers for correctable and uncorrectable ECC errors and for uncorrectable errors seen during read-modify-write. Each capture holds the first failure until software clears the matching status bit. The block also counts correctable errors with a saturating counter. It holds the configuration that the controller consumes: error-response control, ECC control, fault-injection data, syndrome and counter, and per-bank timing-margin fields. A read-only size code is derived from the memory-size parameter. The memory array, the ECC logic and the injection datapath are outside this block.

Top module: `memctl_csr`

## Requirements
- R1: After synchronous reset, the status register (0x04) reads 0, the mask (0x08) reads 0x7FF, the read-margin register (0x60) reads 0x249, the correctable count (0x6C) and all writable control registers read 0, and `irq` is low.
- R2: Status bit i (i = 0..10, on `evt_i[i]`) is set one cycle after its event input is high. Writing 1 to a status bit clears it, writing 0 leaves it, and a software write never sets a status bit. Bits 31:11 read 0. Bit 6 is the correctable ECC event, bit 7 the uncorrectable one, bit 10 the read-modify-write uncorrectable one and bit 0 the invalid-access flag.
- R3: A write to 0x0C ORs bits 10:0 of the data into the mask. A write to 0x10 clears the mask bits written as 1. Both offsets read 0. A write to 0x08 leaves the mask unchanged.
- R4: `irq` is high exactly when (status AND mask) is nonzero.
- R5: When an event sets a status bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R6: An event on bit 6 loads the correctable capture only if status bit 6 is clear. The capture is the 18-bit address at 0x1C, four data words at 0x20/0x24/0x28/0x2C (word k is data bits 32k+31:32k) and the 16-bit syndrome at 0x30. Bit 7 loads the uncorrectable capture at 0x34, 0x38..0x44 and 0x48 under the same rule. Bit 10 loads the 18-bit address at 0x70 under the same rule. While the bit is set, later events leave the captures unchanged.
- R7: The 16-bit correctable count at 0x6C increments on every cycle with `evt_i[6]` high and saturates at 0xFFFF. Writing ones clears those count bits. When an increment and a clear write fall in the same cycle, the increment wins and the write is dropped.
- R8: Read/write registers keep only their defined bits and drive their output ports. These are error control at 0x00 (4 bits), ECC control at 0x14 (3 bits), injection data words at 0x4C..0x58 (word k at 0x4C+4k), injection syndrome at 0x5C (16 bits), margins at 0x60 (12 bits, four 3-bit fields), 0x64 (8 bits) and 0x68 (4 bits), and the injection counter at 0x74 (24 bits).
- R9: Capture registers, 0x70, the debug syndrome registers at 0x78 and 0x7C (which show `dbg_tomem_i` and `dbg_frommem_i`) and the size register ignore writes.
- R10: The size register at 0x80 reads 0 for 64 KiB, 1 for 128 KiB, 2 for 256 KiB (default) and 3 for 512 KiB. Any other `MEM_BYTES` fails elaboration.
- R11: An access to an offset outside the defined set (any offset above 0x80, offset 0x18, or any address with bits 1:0 nonzero) reads 0 and sets status bit 0 one cycle after its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq | output | 1 | Level interrupt |
| evt_i | input | 11 | Hardware event per status bit |
| ce_addr_i | input | 18 | Correctable failure address |
| ce_data_i | input | 128 | Correctable failure data |
| ce_syn_i | input | 16 | Correctable failure syndrome |
| ue_addr_i | input | 18 | Uncorrectable failure address |
| ue_data_i | input | 128 | Uncorrectable failure data |
| ue_syn_i | input | 16 | Uncorrectable failure syndrome |
| rmw_addr_i | input | 18 | Read-modify-write failure address |
| dbg_tomem_i | input | 32 | Debug syndrome toward memory |
| dbg_frommem_i | input | 32 | Debug syndrome from memory |
| err_cfg_o | output | 4 | Error-response control |
| ecc_cfg_o | output | 3 | ECC control |
| inj_data_o | output | 128 | Fault-injection data |
| inj_syn_o | output | 16 | Fault-injection syndrome |
| inj_count_o | output | 24 | Fault-injection counter |
| margin_rd_o | output | 12 | Per-bank 3-bit margins |
| margin_wr_o | output | 8 | Per-bank 2-bit margins |
| margin_sel_o | output | 4 | Per-bank 1-bit margins |

## Verification
Two pairs of functions can land in the same cycle. One pair is a hardware event setting a status bit while software writes 1 to clear that bit. The other is a correctable event incrementing the count while software clears the count. The bench raises the event input during the access phase of the clearing write, so both act at the same clock edge. It then reads back that the status bit is still set and that the count is the old value plus one.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

    localparam int CSR_AW = 12;
    localparam int NSRC   = 11;

    // status bit positions (the interrupt group's bit order)
    localparam int SRC_BAD_ACCESS = 0;
    localparam int SRC_ECC_CE     = 6;
    localparam int SRC_ECC_UE     = 7;
    localparam int SRC_RMW_UE     = 10;

    localparam logic [CSR_AW-1:0] OFF_ERR_CFG    = 12'h000;
    localparam logic [CSR_AW-1:0] OFF_INT_STAT   = 12'h004;
    localparam logic [CSR_AW-1:0] OFF_INT_MASK   = 12'h008;
    localparam logic [CSR_AW-1:0] OFF_INT_EN     = 12'h00C;
    localparam logic [CSR_AW-1:0] OFF_INT_DIS    = 12'h010;
    localparam logic [CSR_AW-1:0] OFF_ECC_CFG    = 12'h014;
    localparam logic [CSR_AW-1:0] OFF_CE_ADDR    = 12'h01C;
    localparam logic [CSR_AW-1:0] OFF_CE_DATA    = 12'h020;
    localparam logic [CSR_AW-1:0] OFF_CE_SYN     = 12'h030;
    localparam logic [CSR_AW-1:0] OFF_UE_ADDR    = 12'h034;
    localparam logic [CSR_AW-1:0] OFF_UE_DATA    = 12'h038;
    localparam logic [CSR_AW-1:0] OFF_UE_SYN     = 12'h048;
    localparam logic [CSR_AW-1:0] OFF_INJ_DATA   = 12'h04C;
    localparam logic [CSR_AW-1:0] OFF_INJ_SYN    = 12'h05C;
    localparam logic [CSR_AW-1:0] OFF_MARGIN_RD  = 12'h060;
    localparam logic [CSR_AW-1:0] OFF_MARGIN_WR  = 12'h064;
    localparam logic [CSR_AW-1:0] OFF_MARGIN_SEL = 12'h068;
    localparam logic [CSR_AW-1:0] OFF_CE_COUNT   = 12'h06C;
    localparam logic [CSR_AW-1:0] OFF_RMW_ADDR   = 12'h070;
    localparam logic [CSR_AW-1:0] OFF_INJ_COUNT  = 12'h074;
    localparam logic [CSR_AW-1:0] OFF_DBG_TOMEM  = 12'h078;
    localparam logic [CSR_AW-1:0] OFF_DBG_FROMEM = 12'h07C;
    localparam logic [CSR_AW-1:0] OFF_SIZE       = 12'h080;

    typedef struct packed {
        logic                 wr;      // write access phase
        logic                 acc;     // any access phase
        logic [CSR_AW-1:0]    addr;
        logic [31:0]          wdata;
    } csr_req_t;

    function automatic bit size_ok(input longint unsigned bytes);
        return (bytes == 64'd65536) || (bytes == 64'd131072) ||
               (bytes == 64'd262144) || (bytes == 64'd524288);
    endfunction

    function automatic logic [3:0] size_code(input longint unsigned bytes);
        logic [3:0] c;
        case (bytes)
            64'd65536:  c = 4'd0;
            64'd131072: c = 4'd1;
            64'd262144: c = 4'd2;
            64'd524288: c = 4'd3;
            default:    c = 4'hF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/memctl_irq_group.sv
module memctl_irq_group #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_we_i,
    input  logic         ien_we_i,
    input  logic         ids_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] status_q, mask_q, clr_bits;

    assign clr_bits = clr_we_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            // hardware set is applied after the clear so it wins
            status_q <= (status_q & ~clr_bits) | set_i;
            if (ien_we_i)
                mask_q <= mask_q | wdata_i;
            else if (ids_we_i)
                mask_q <= mask_q & ~wdata_i;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & mask_q);

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R5

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0) |=> ((status_q & ~$past(status_q)) == '0)); // R2

    AST_MASK_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (rst)
        !(ien_we_i || ids_we_i) |=> $stable(mask_q)); // R3

endmodule

// File: rtl/memctl_ff_capture.sv
module memctl_ff_capture #(
    parameter int AW = 18,
    parameter int DW = 128,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          event_i,
    input  logic          held_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [SW-1:0] syn_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic [SW-1:0] syn_o
);
    logic load;
    assign load = event_i && !held_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            data_o <= '0;
            syn_o  <= '0;
        end else if (load) begin
            addr_o <= addr_i;
            data_o <= data_i;
            syn_o  <= syn_i;
        end
    end

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
        held_i |=> ($stable(addr_o) && $stable(data_o) && $stable(syn_o))); // R6

endmodule

// File: rtl/memctl_sat_counter.sv
module memctl_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (inc_i)
            count_o <= (count_o == CMAX) ? CMAX : count_o + W'(1);
        else if (clr_we_i)
            count_o <= count_o & ~clr_bits_i;
    end

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (inc_i && count_o == CMAX) |=> (count_o == CMAX)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && count_o != CMAX) |=> (count_o == $past(count_o) + W'(1))); // R7

endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import memctl_csr_pkg::*;
#(
    parameter longint unsigned MEM_BYTES = 262144,
    parameter int CAP_AW      = 18,
    parameter int DATA_WORDS  = 4,
    parameter int SYN_W       = 16,
    parameter int CE_CNT_W    = 16,
    parameter int INJ_CNT_W   = 24,
    parameter int NUM_BANKS   = 4,
    parameter int MARGIN_RD_W = 3,
    parameter int MARGIN_WR_W = 2,
    parameter int ERR_CFG_W   = 4,
    parameter int ECC_CFG_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            psel,
    input  logic                            penable,
    input  logic                            pwrite,
    input  logic [11:0]                     paddr,
    input  logic [31:0]                     pwdata,
    output logic [31:0]                     prdata,
    output logic                            irq,
    input  logic [10:0]                     evt_i,
    input  logic [CAP_AW-1:0]               ce_addr_i,
    input  logic [DATA_WORDS*32-1:0]        ce_data_i,
    input  logic [SYN_W-1:0]                ce_syn_i,
    input  logic [CAP_AW-1:0]               ue_addr_i,
    input  logic [DATA_WORDS*32-1:0]        ue_data_i,
    input  logic [SYN_W-1:0]                ue_syn_i,
    input  logic [CAP_AW-1:0]               rmw_addr_i,
    input  logic [31:0]                     dbg_tomem_i,
    input  logic [31:0]                     dbg_frommem_i,
    output logic [ERR_CFG_W-1:0]            err_cfg_o,
    output logic [ECC_CFG_W-1:0]            ecc_cfg_o,
    output logic [DATA_WORDS*32-1:0]        inj_data_o,
    output logic [SYN_W-1:0]                inj_syn_o,
    output logic [INJ_CNT_W-1:0]            inj_count_o,
    output logic [NUM_BANKS*MARGIN_RD_W-1:0] margin_rd_o,
    output logic [NUM_BANKS*MARGIN_WR_W-1:0] margin_wr_o,
    output logic [NUM_BANKS-1:0]            margin_sel_o
);
    localparam int DBITS = DATA_WORDS * 32;
    localparam int MRD_W = NUM_BANKS * MARGIN_RD_W;
    localparam int MWR_W = NUM_BANKS * MARGIN_WR_W;
    localparam logic [MRD_W-1:0] MRD_RST = {NUM_BANKS{MARGIN_RD_W'(1)}};
    localparam logic [3:0] SIZE_CODE = size_code(MEM_BYTES);

    generate
        if (!size_ok(MEM_BYTES)) begin : g_bad_size
            $error("memctl_csr: MEM_BYTES must be 64, 128, 256 or 512 KiB");
        end
    endgenerate

    csr_req_t req;
    assign req.acc   = psel && penable;
    assign req.wr    = psel && penable && pwrite;
    assign req.addr  = paddr;
    assign req.wdata = pwdata;

    // ---------------- interrupt group ----------------
    logic [NSRC-1:0] int_status, int_mask, int_set;
    logic            hit;
    logic [31:0]     rdata;
    logic            bad_access;

    assign bad_access = req.acc && !hit;

    always_comb begin
        int_set = evt_i;
        int_set[SRC_BAD_ACCESS] = evt_i[SRC_BAD_ACCESS] | bad_access;
    end

    memctl_irq_group #(.N(NSRC)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (int_set),
        .clr_we_i (req.wr && req.addr == OFF_INT_STAT),
        .ien_we_i (req.wr && req.addr == OFF_INT_EN),
        .ids_we_i (req.wr && req.addr == OFF_INT_DIS),
        .wdata_i  (req.wdata[NSRC-1:0]),
        .status_o (int_status),
        .mask_o   (int_mask),
        .irq_o    (irq)
    );

    // ---------------- first-failure captures ----------------
    logic [CAP_AW-1:0] ce_addr_q, ue_addr_q, rmw_addr_q;
    logic [DBITS-1:0]  ce_data_q, ue_data_q;
    logic [SYN_W-1:0]  ce_syn_q, ue_syn_q;
    logic [DBITS-1:0]  rmw_unused_data;
    logic [SYN_W-1:0]  rmw_unused_syn;

    memctl_ff_capture #(.AW(CAP_AW), .DW(DBITS), .SW(SYN_W)) u_cap_ce (
        .clk(clk), .rst(rst),
        .event_i(evt_i[SRC_ECC_CE]), .held_i(int_status[SRC_ECC_CE]),
        .addr_i(ce_addr_i), .data_i(ce_data_i), .syn_i(ce_syn_i),
        .addr_o(ce_addr_q), .data_o(ce_data_q), .syn_o(ce_syn_q)
    );

    memctl_ff_capture #(.AW(CAP_AW), .DW(DBITS), .SW(SYN_W)) u_cap_ue (
        .clk(clk), .rst(rst),
        .event_i(evt_i[SRC_ECC_UE]), .held_i(int_status[SRC_ECC_UE]),
        .addr_i(ue_addr_i), .data_i(ue_data_i), .syn_i(ue_syn_i),
        .addr_o(ue_addr_q), .data_o(ue_data_q), .syn_o(ue_syn_q)
    );

    // address-only capture: data and syndrome inputs tied off
    memctl_ff_capture #(.AW(CAP_AW), .DW(DBITS), .SW(SYN_W)) u_cap_rmw (
        .clk(clk), .rst(rst),
        .event_i(evt_i[SRC_RMW_UE]), .held_i(int_status[SRC_RMW_UE]),
        .addr_i(rmw_addr_i), .data_i('0), .syn_i('0),
        .addr_o(rmw_addr_q), .data_o(rmw_unused_data), .syn_o(rmw_unused_syn)
    );

    // ---------------- correctable count ----------------
    logic [CE_CNT_W-1:0] ce_count;

    memctl_sat_counter #(.W(CE_CNT_W)) u_ce_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_i      (evt_i[SRC_ECC_CE]),
        .clr_we_i   (req.wr && req.addr == OFF_CE_COUNT),
        .clr_bits_i (req.wdata[CE_CNT_W-1:0]),
        .count_o    (ce_count)
    );

    // ---------------- read/write control registers ----------------
    logic [ERR_CFG_W-1:0] err_cfg_q;
    logic [ECC_CFG_W-1:0] ecc_cfg_q;
    logic [31:0]          inj_data_q [DATA_WORDS];
    logic [SYN_W-1:0]     inj_syn_q;
    logic [INJ_CNT_W-1:0] inj_count_q;
    logic [MRD_W-1:0]     margin_rd_q;
    logic [MWR_W-1:0]     margin_wr_q;
    logic [NUM_BANKS-1:0] margin_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cfg_q    <= '0;
            ecc_cfg_q    <= '0;
            inj_syn_q    <= '0;
            inj_count_q  <= '0;
            margin_rd_q  <= MRD_RST;
            margin_wr_q  <= '0;
            margin_sel_q <= '0;
        end else if (req.wr) begin
            case (req.addr)
                OFF_ERR_CFG:    err_cfg_q    <= req.wdata[ERR_CFG_W-1:0];
                OFF_ECC_CFG:    ecc_cfg_q    <= req.wdata[ECC_CFG_W-1:0];
                OFF_INJ_SYN:    inj_syn_q    <= req.wdata[SYN_W-1:0];
                OFF_INJ_COUNT:  inj_count_q  <= req.wdata[INJ_CNT_W-1:0];
                OFF_MARGIN_RD:  margin_rd_q  <= req.wdata[MRD_W-1:0];
                OFF_MARGIN_WR:  margin_wr_q  <= req.wdata[MWR_W-1:0];
                OFF_MARGIN_SEL: margin_sel_q <= req.wdata[NUM_BANKS-1:0];
                default: ;
            endcase
        end
    end

    generate
        for (genvar k = 0; k < DATA_WORDS; k++) begin : g_inj_word
            localparam logic [CSR_AW-1:0] WOFF = OFF_INJ_DATA + CSR_AW'(4 * k);
            always_ff @(posedge clk) begin
                if (rst)
                    inj_data_q[k] <= '0;
                else if (req.wr && req.addr == WOFF)
                    inj_data_q[k] <= req.wdata;
            end
            assign inj_data_o[32*k +: 32] = inj_data_q[k];
        end
    endgenerate

    assign err_cfg_o    = err_cfg_q;
    assign ecc_cfg_o    = ecc_cfg_q;
    assign inj_syn_o    = inj_syn_q;
    assign inj_count_o  = inj_count_q;
    assign margin_rd_o  = margin_rd_q;
    assign margin_wr_o  = margin_wr_q;
    assign margin_sel_o = margin_sel_q;

    // ---------------- read decode ----------------
    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        if (req.addr[1:0] != 2'b00) begin
            hit = 1'b0;
        end else begin
            case (req.addr)
                OFF_ERR_CFG:    rdata = 32'(err_cfg_q);
                OFF_INT_STAT:   rdata = 32'(int_status);
                OFF_INT_MASK:   rdata = 32'(int_mask);
                OFF_INT_EN:     rdata = '0;
                OFF_INT_DIS:    rdata = '0;
                OFF_ECC_CFG:    rdata = 32'(ecc_cfg_q);
                OFF_CE_ADDR:    rdata = 32'(ce_addr_q);
                OFF_CE_SYN:     rdata = 32'(ce_syn_q);
                OFF_UE_ADDR:    rdata = 32'(ue_addr_q);
                OFF_UE_SYN:     rdata = 32'(ue_syn_q);
                OFF_INJ_SYN:    rdata = 32'(inj_syn_q);
                OFF_MARGIN_RD:  rdata = 32'(margin_rd_q);
                OFF_MARGIN_WR:  rdata = 32'(margin_wr_q);
                OFF_MARGIN_SEL: rdata = 32'(margin_sel_q);
                OFF_CE_COUNT:   rdata = 32'(ce_count);
                OFF_RMW_ADDR:   rdata = 32'(rmw_addr_q);
                OFF_INJ_COUNT:  rdata = 32'(inj_count_q);
                OFF_DBG_TOMEM:  rdata = dbg_tomem_i;
                OFF_DBG_FROMEM: rdata = dbg_frommem_i;
                OFF_SIZE:       rdata = 32'(SIZE_CODE);
                default: begin
                    hit = 1'b0;
                    for (int k = 0; k < DATA_WORDS; k++) begin
                        if (req.addr == OFF_CE_DATA + CSR_AW'(4 * k)) begin
                            hit = 1'b1; rdata = ce_data_q[32*k +: 32];
                        end
                        if (req.addr == OFF_UE_DATA + CSR_AW'(4 * k)) begin
                            hit = 1'b1; rdata = ue_data_q[32*k +: 32];
                        end
                        if (req.addr == OFF_INJ_DATA + CSR_AW'(4 * k)) begin
                            hit = 1'b1; rdata = inj_data_q[k];
                        end
                    end
                end
            endcase
        end
    end

    assign prdata = psel ? rdata : '0;

    AST_BAD_ADDR_FLAG: assert property (@(posedge clk) disable iff (rst)
        bad_access |=> int_status[SRC_BAD_ACCESS]); // R11

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (int_status == '0) |-> !irq); // R4

endmodule

// File: tb/test_memctl_csr.sv
module test_memctl_csr;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         psel = 0, penable = 0, pwrite = 0;
    logic [11:0]  paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         irq;
    logic [10:0]  evt = '0;
    logic [17:0]  ce_addr = '0, ue_addr = '0, rmw_addr = '0;
    logic [127:0] ce_data = '0, ue_data = '0;
    logic [15:0]  ce_syn = '0, ue_syn = '0;
    logic [31:0]  dbg_to = 32'hA5A5_0001, dbg_from = 32'h5A5A_0002;
    logic [3:0]   err_cfg;
    logic [2:0]   ecc_cfg;
    logic [127:0] inj_data;
    logic [15:0]  inj_syn;
    logic [23:0]  inj_count;
    logic [11:0]  m_rd;
    logic [7:0]   m_wr;
    logic [3:0]   m_sel;

    int total = 0;
    int bad = 0;
    int ce_expect = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memctl_csr i_memctl_csr (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .evt_i(evt),
        .ce_addr_i(ce_addr), .ce_data_i(ce_data), .ce_syn_i(ce_syn),
        .ue_addr_i(ue_addr), .ue_data_i(ue_data), .ue_syn_i(ue_syn),
        .rmw_addr_i(rmw_addr), .dbg_tomem_i(dbg_to), .dbg_frommem_i(dbg_from),
        .err_cfg_o(err_cfg), .ecc_cfg_o(ecc_cfg), .inj_data_o(inj_data),
        .inj_syn_o(inj_syn), .inj_count_o(inj_count), .margin_rd_o(m_rd),
        .margin_wr_o(m_wr), .margin_sel_o(m_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse(input logic [10:0] m);
        @(negedge clk); evt = m;
        @(negedge clk); evt = '0;
    endtask

    task automatic chk_cap(input string tag, input logic [11:0] a, input logic [11:0] d,
                           input logic [11:0] s, input logic [17:0] ea,
                           input logic [127:0] ed, input logic [15:0] es);
        rdchk(tag, a, 32'(ea));
        for (int k = 0; k < 4; k++) rdchk(tag, d + 12'(4 * k), ed[32*k +: 32]);
        rdchk(tag, s, 32'(es));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [127:0] da, db;
        logic [31:0] pats [4];
        logic [11:0] rw_off [11];
        logic [31:0] rw_msk [11];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5;
        pats[2] = 32'h5A5A_5A5A; pats[3] = 32'h0;
        rw_off[0] = 12'h000; rw_msk[0] = 32'hF;
        rw_off[1] = 12'h014; rw_msk[1] = 32'h7;
        for (int k = 0; k < 4; k++) begin
            rw_off[2+k] = 12'h04C + 12'(4 * k); rw_msk[2+k] = 32'hFFFF_FFFF;
        end
        rw_off[6] = 12'h05C; rw_msk[6] = 32'hFFFF;
        rw_off[7] = 12'h060; rw_msk[7] = 32'hFFF;
        rw_off[8] = 12'h064; rw_msk[8] = 32'hFF;
        rw_off[9] = 12'h068; rw_msk[9] = 32'hF;
        rw_off[10] = 12'h074; rw_msk[10] = 32'hFF_FFFF;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        rdchk("R1 status", 12'h004, 0);
        rdchk("R1 mask", 12'h008, 32'h7FF);
        rdchk("R1 margin_rd", 12'h060, 32'h249);
        rdchk("R1 count", 12'h06C, 0);
        for (int i = 0; i < 11; i++) rdchk("R1 rw", rw_off[i], (i == 7) ? 32'h249 : 0);
        rdchk("R10 size", 12'h080, 32'd2);

        // R9 read-only registers
        rdchk("R9 dbg_to", 12'h078, dbg_to);
        rdchk("R9 dbg_from", 12'h07C, dbg_from);
        wr(12'h078, 32'h1234); wr(12'h07C, 32'h1234); wr(12'h080, 32'hF);
        wr(12'h01C, 32'h3FFFF); wr(12'h070, 32'h3FFFF); wr(12'h030, 32'hFFFF);
        rdchk("R9 dbg_to", 12'h078, dbg_to);
        rdchk("R9 dbg_from", 12'h07C, dbg_from);
        rdchk("R9 size", 12'h080, 32'd2);
        rdchk("R9 ce_addr", 12'h01C, 0);
        rdchk("R9 rmw_addr", 12'h070, 0);
        rdchk("R9 ce_syn", 12'h030, 0);

        // R3 enable/disable/mask
        wr(12'h010, 32'h7FF);
        rdchk("R3 mask cleared", 12'h008, 0);
        rdchk("R3 en reads 0", 12'h00C, 0);
        rdchk("R3 dis reads 0", 12'h010, 0);
        wr(12'h008, 32'h7FF);
        rdchk("R3 mask ro", 12'h008, 0);
        for (int i = 0; i < 11; i++) begin
            wr(12'h00C, 32'(1) << i);
            rdchk("R3 mask accumulate", 12'h008, (32'(2) << i) - 1);
        end
        wr(12'h010, 32'h0AA);
        rdchk("R3 mask partial clear", 12'h008, 32'h755);
        wr(12'h00C, 32'hFFFF_FFFF);
        rdchk("R3 mask reserved", 12'h008, 32'h7FF);

        // R2/R4 per-bit sweep
        for (int i = 0; i < 11; i++) begin
            wr(12'h004, 32'h7FF);
            rdchk("R2 sw cannot set", 12'h004, 0);
            pulse(11'(1) << i);
            if (i == 6) ce_expect++;
            rdchk("R2 hw set", 12'h004, 32'(1) << i);
            chk("R4 irq on", 32'(irq), 1);
            wr(12'h010, 32'(1) << i);
            chk("R4 irq masked", 32'(irq), 0);
            wr(12'h00C, 32'(1) << i);
            chk("R4 irq unmasked", 32'(irq), 1);
            wr(12'h004, ~(32'(1) << i));
            rdchk("R2 w1c others", 12'h004, 32'(1) << i);
            wr(12'h004, 32'(1) << i);
            rdchk("R2 w1c clear", 12'h004, 0);
            chk("R4 irq off", 32'(irq), 0);
        end
        pulse(11'h505);
        rdchk("R2 multi", 12'h004, 32'h505);
        wr(12'h010, 32'h505);
        chk("R4 multi masked", 32'(irq), 0);
        wr(12'h00C, 32'h001);
        chk("R4 one unmasked", 32'(irq), 1);
        wr(12'h00C, 32'h7FF);
        wr(12'h004, 32'h7FF);

        // R5 set vs clear in the same cycle
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h004; pwdata = 32'h8;
        pulse_wait: begin end
        @(negedge clk); penable = 1; evt = 11'h008;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; evt = '0;
        rdchk("R5 set wins", 12'h004, 32'h8);
        wr(12'h004, 32'h8);
        rdchk("R5 cleared after", 12'h004, 0);

        // R6 first-failure capture
        da = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        db = ~da;
        ce_addr = 18'h2_1234; ce_data = da; ce_syn = 16'hBEEF;
        pulse(11'(1) << 6); ce_expect++;
        chk_cap("R6 ce first", 12'h01C, 12'h020, 12'h030, 18'h2_1234, da, 16'hBEEF);
        ce_addr = 18'h1_5555; ce_data = db; ce_syn = 16'h1111;
        pulse(11'(1) << 6); ce_expect++;
        chk_cap("R6 ce held", 12'h01C, 12'h020, 12'h030, 18'h2_1234, da, 16'hBEEF);
        wr(12'h004, 32'(1) << 6);
        pulse(11'(1) << 6); ce_expect++;
        chk_cap("R6 ce reload", 12'h01C, 12'h020, 12'h030, 18'h1_5555, db, 16'h1111);
        ue_addr = 18'h3_0F0F; ue_data = db; ue_syn = 16'hCAFE;
        pulse(11'(1) << 7);
        chk_cap("R6 ue first", 12'h034, 12'h038, 12'h048, 18'h3_0F0F, db, 16'hCAFE);
        ue_addr = 18'h0_0001; ue_data = da; ue_syn = 16'h0002;
        pulse(11'(1) << 7);
        chk_cap("R6 ue held", 12'h034, 12'h038, 12'h048, 18'h3_0F0F, db, 16'hCAFE);
        wr(12'h038, 32'h0);
        rdchk("R9 ue data ro", 12'h038, db[31:0]);
        rmw_addr = 18'h2_AAAA;
        pulse(11'(1) << 10);
        rdchk("R6 rmw first", 12'h070, 32'h2_AAAA);
        rmw_addr = 18'h0_0BBB;
        pulse(11'(1) << 10);
        rdchk("R6 rmw held", 12'h070, 32'h2_AAAA);
        wr(12'h004, 32'h7FF);
        pulse(11'(1) << 10);
        rdchk("R6 rmw reload", 12'h070, 32'h0_0BBB);
        wr(12'h004, 32'h7FF);

        // R7 correctable count
        rdchk("R7 count", 12'h06C, 32'(ce_expect));
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h06C; pwdata = 32'hFFFF;
        @(negedge clk); penable = 1; evt = 11'(1) << 6;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; evt = '0;
        ce_expect++;
        rdchk("R7 inc wins", 12'h06C, 32'(ce_expect));
        wr(12'h06C, 32'h1);
        rdchk("R7 w1c bit", 12'h06C, 32'(ce_expect) & ~32'h1);
        wr(12'h06C, 32'hFFFF);
        rdchk("R7 w1c all", 12'h06C, 0);
        @(negedge clk); evt = 11'(1) << 6;
        repeat (65540) @(negedge clk);
        evt = '0;
        rdchk("R7 saturate", 12'h06C, 32'hFFFF);
        wr(12'h06C, 32'h00FF);
        rdchk("R7 partial clear", 12'h06C, 32'hFF00);
        wr(12'h004, 32'h7FF);

        // R8 read/write registers
        foreach (pats[p]) begin
            for (int i = 0; i < 11; i++) begin
                wr(rw_off[i], pats[p]);
                rdchk("R8 rw width", rw_off[i], pats[p] & rw_msk[i]);
            end
        end
        wr(12'h000, 32'h9); wr(12'h014, 32'h5); wr(12'h05C, 32'h1357_2468);
        wr(12'h074, 32'hAB12_3456); wr(12'h060, 32'h0000_0ACE);
        wr(12'h064, 32'h0000_01C3); wr(12'h068, 32'h0000_0016);
        for (int k = 0; k < 4; k++) wr(12'h04C + 12'(4 * k), 32'h1111_0000 * (k + 1));
        chk("R8 err_cfg port", 32'(err_cfg), 32'h9);
        chk("R8 ecc_cfg port", 32'(ecc_cfg), 32'h5);
        chk("R8 inj_syn port", 32'(inj_syn), 32'h2468);
        chk("R8 inj_count port", 32'(inj_count), 32'h12_3456);
        chk("R8 margin_rd port", 32'(m_rd), 32'hACE);
        chk("R8 margin_wr port", 32'(m_wr), 32'hC3);
        chk("R8 margin_sel port", 32'(m_sel), 32'h6);
        for (int k = 0; k < 4; k++)
            chk("R8 inj_data port", inj_data[32*k +: 32], 32'h1111_0000 * (k + 1));

        // R11 undefined offsets
        rdchk("R11 status before", 12'h004, 0);
        rdchk("R11 hole", 12'h018, 0);
        rdchk("R11 flag hole", 12'h004, 32'h1);
        wr(12'h004, 32'h1);
        wr(12'h084, 32'hFFFF_FFFF);
        rdchk("R11 flag write", 12'h004, 32'h1);
        wr(12'h004, 32'h1);
        rdchk("R11 misaligned", 12'h006, 0);
        rdchk("R11 flag misaligned", 12'h004, 32'h1);
        wr(12'h004, 32'h1);
        for (int off = 0; off < 4096; off += 4) begin
            if (off > 'h80 || off == 'h18)
                rdchk("R11 sweep", 12'(off), 0);
        end
        rdchk("R11 flag sweep", 12'h004, 32'h1);
        chk("R4 irq from flag", 32'(irq), 1);

        finish_run();
    end
endmodule